// File: doc/BRIEF.md
# Four-Shape Waveform Sample Generator

This block produces a stream of unsigned amplitude samples for a digital-to-analog path. It holds a phase counter that moves one step each time the sample strobe is high. On each strobe it emits the amplitude of the selected shape at the current phase, together with a 10-bit address that combines the shape code and the phase. Four shapes are available: sine, square, triangle and sawtooth. One period of any shape is 256 samples long.

Square, triangle and sawtooth are worked out from the phase by small arithmetic. Sine comes from a constant table of 256 entries that is computed while the design elaborates, so no memory file is loaded. The output pair (address, amplitude) sits in a register. It changes only on a strobe cycle and is valid from the clock edge that takes the strobe. Changing the shape select does not touch the phase, so a new shape carries on from the point the old one had reached.

Top module: `fgen_core`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the phase to 0 and sets addr to 0x000 and amplitude to 0x80, the sine value at phase 0. After reset the first strobe produces phase 0.
- R2: The phase advances by one, wrapping from 255 to 0, only at edges where sample_en is high. At edges where sample_en is low, addr and amplitude hold their values, and a change of fsel has no effect on them.
- R3: The sample taken on a strobe has addr = {fsel, phase}, with fsel in bits 9:8 and the phase in bits 7:0. The fsel codes are 00 sine, 01 square, 10 triangle and 11 sawtooth.
- R4: The sawtooth amplitude equals the phase, 0x00 up to 0xFF.
- R5: The square amplitude is 0xFF for phases 0 to 127 and 0x00 for phases 128 to 255.
- R6: The triangle amplitude for phase p is 128+2p when p<64, 256−2(p−63) when 64≤p≤191, and 2(p−191) when p≥192.
- R7: The sine amplitude for phase p is the truncated value of 128·sin(p·2π/256)+128, saturated to 255, with π taken as 3.1416. Phases 0 to 3 give 0x80, 0x83, 0x86 and 0x89, phase 64 gives 0xFF, and phase 128 gives 0x7F.
- R8: A new fsel value applies from the next strobe. The phase continues from where it was and is not reset.
- R9: The amplitude for a strobe appears at the rising edge that samples the strobe, which is one register after the phase. Before that edge the outputs still show the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Sample strobe; steps the phase and loads the outputs |
| fsel | input | 2 | Shape select: 00 sine, 01 square, 10 triangle, 11 sawtooth |
| amplitude | output | 8 | Registered unsigned sample value |
| addr | output | 10 | Registered {shape, phase} of the current sample |

## Verification
The bench builds the block with its default phase width of 8. A single period is then only 256 strobes long, so four back-to-back sweeps cover every address from 0x000 to 0x3FF, including the wrap of the phase and every bend of the triangle. The short period also leaves room in the run for strobes with gaps between them, a shape change on every strobe, and a reset in the middle of a sweep.

// File: rtl/fgen_pkg.sv
// Package fgen_pkg: shared shape codes and constants for the function generator.
// Assumes: the shape code is two bits wide and sits above the phase in the address.
package fgen_pkg;
    localparam int SEL_W = 2;
    localparam real PI_APPROX = 3.1416;

    typedef enum logic [SEL_W-1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_TRI    = 2'd2,
        WAVE_SAW    = 2'd3
    } wave_e;
endpackage

// File: rtl/fgen_phase.sv
// Module fgen_phase: free-running phase counter that moves one step per strobe.
// Assumes: the counter wraps naturally at 2**PHASE_W; reset is synchronous, active low.
module fgen_phase #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    output logic [PHASE_W-1:0] phase
);
    // Phase register: clear on reset, increment on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (step)
            phase <= phase + 1'b1;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phase == $past(phase) + 1'b1); // R2
endmodule

// File: rtl/fgen_sine_rom.sv
// Module fgen_sine_rom: constant sine lookup, one entry per phase, built at elaboration.
// Assumes: the output width equals the phase width; values saturate at all-ones.
module fgen_sine_rom #(
    parameter int PHASE_W = 8
) (
    input  logic [PHASE_W-1:0] idx,
    output logic [PHASE_W-1:0] val
);
    import fgen_pkg::*;

    localparam int DEPTH = 2 ** PHASE_W;
    localparam int HALF  = DEPTH / 2;
    localparam int MAXV  = DEPTH - 1;

    typedef logic [DEPTH-1:0][PHASE_W-1:0] tbl_t;

    // Compute every entry as offset sine, truncated, then clamped to range.
    function automatic tbl_t build_tbl();
        tbl_t t;
        real  ang;
        real  v;
        int   iv;
        for (int i = 0; i < DEPTH; i++) begin
            ang = real'(i) * 2.0 * PI_APPROX / real'(DEPTH);
            v   = real'(HALF) * $sin(ang) + real'(HALF);
            iv  = $rtoi(v);
            if (iv > MAXV) iv = MAXV;
            if (iv < 0)    iv = 0;
            t[i] = iv[PHASE_W-1:0];
        end
        return t;
    endfunction

    localparam tbl_t SINE_TBL = build_tbl();

    // Table read: pure combinational lookup.
    assign val = SINE_TBL[idx];
endmodule

// File: rtl/fgen_shape.sv
// Module fgen_shape: forms the amplitude of the selected shape from the phase.
// Assumes: square, triangle and sawtooth are arithmetic; sine arrives from the table.
module fgen_shape #(
    parameter int PHASE_W = 8
) (
    input  fgen_pkg::wave_e    sel,
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] sine_val,
    output logic [PHASE_W-1:0] amp
);
    import fgen_pkg::*;

    localparam int N = 2 ** PHASE_W;
    localparam int Q = N / 4;

    logic [PHASE_W-1:0] tri_val;
    logic [PHASE_W-1:0] sq_val;
    int                 p_i;
    int                 t_i;

    // Triangle: rise from mid-scale, long fall, then rise back to mid-scale.
    always_comb begin
        p_i = int'(phase);
        if (p_i < Q)
            t_i = N / 2 + 2 * p_i;
        else if (p_i < 3 * Q)
            t_i = N - 2 * (p_i - (Q - 1));
        else
            t_i = 2 * (p_i - (3 * Q - 1));
        tri_val = t_i[PHASE_W-1:0];
    end

    // Square: high for the first half period, low for the second.
    assign sq_val = {PHASE_W{~phase[PHASE_W-1]}};

    // Shape select.
    always_comb begin
        unique case (sel)
            WAVE_SINE:   amp = sine_val;
            WAVE_SQUARE: amp = sq_val;
            WAVE_TRI:    amp = tri_val;
            WAVE_SAW:    amp = phase;
            default:     amp = phase;
        endcase
    end
endmodule

// File: rtl/fgen_core.sv
// Module fgen_core: four-shape sample generator with registered {shape, phase} address.
// Assumes: one phase step per strobe; outputs load only on strobe cycles;
// reset is synchronous, active low, and leaves the sine sample of phase 0.
module fgen_core #(
    parameter int PHASE_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sample_en,
    input  logic [fgen_pkg::SEL_W-1:0]           fsel,
    output logic [PHASE_W-1:0]                   amplitude,
    output logic [fgen_pkg::SEL_W+PHASE_W-1:0]   addr
);
    import fgen_pkg::*;

    localparam int ADDR_W = SEL_W + PHASE_W;
    localparam logic [PHASE_W-1:0] RESET_AMP = PHASE_W'(2 ** (PHASE_W - 1));
    localparam logic [PHASE_W-1:0] PEAK_PH   = PHASE_W'(2 ** (PHASE_W - 2));

    logic [PHASE_W-1:0] phase_w;
    logic [PHASE_W-1:0] sine_w;
    logic [PHASE_W-1:0] shape_w;

    fgen_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sample_en),
        .phase (phase_w)
    );

    fgen_sine_rom #(.PHASE_W(PHASE_W)) u_sine (
        .idx (phase_w),
        .val (sine_w)
    );

    fgen_shape #(.PHASE_W(PHASE_W)) u_shape (
        .sel      (wave_e'(fsel)),
        .phase    (phase_w),
        .sine_val (sine_w),
        .amp      (shape_w)
    );

    // Output register: capture address and amplitude of the current phase on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            amplitude <= RESET_AMP;
        end else if (sample_en) begin
            addr      <= ADDR_W'({fsel, phase_w});
            amplitude <= shape_w;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(addr) && $stable(amplitude)); // R2
    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> addr == {$past(fsel), $past(phase_w)}); // R3
    AST_PHASE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> phase_w == addr[PHASE_W-1:0] + 1'b1); // R8
    AST_SAW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1 -: SEL_W] == WAVE_SAW |-> amplitude == addr[PHASE_W-1:0]); // R4
    AST_SQUARE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1 -: SEL_W] == WAVE_SQUARE |-> (amplitude == '0 || amplitude == '1)); // R5
    AST_SINE_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        addr == {WAVE_SINE, PEAK_PH} |-> amplitude == '1); // R7
endmodule

// File: tb/fgen_core_bench.sv
`timescale 1ns/1ps
module fgen_core_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_en;
    logic [1:0] fsel;
    logic [7:0] amplitude;
    logic [9:0] addr;

    always #5 clk = ~clk;

    fgen_core u_fgen_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .fsel      (fsel),
        .amplitude (amplitude),
        .addr      (addr)
    );

    typedef struct {
        int    a;
        int    v;
        string tag;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    int    model_phase = 0;
    int    last_a = 0;
    int    last_v = 8'h80;
    bit    done = 1'b0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Expected amplitude from the requirement formulas.
    function automatic int exp_amp(int f, int p);
        real v;
        int  iv;
        case (f)
            0: begin
                v  = 128.0 * $sin(real'(p) * 2.0 * 3.1416 / 256.0) + 128.0;
                iv = $rtoi(v);
                if (iv > 255) iv = 255;
                if (iv < 0) iv = 0;
                return iv;
            end
            1: return (p < 128) ? 255 : 0;
            2: begin
                if (p < 64) return 128 + 2 * p;
                else if (p < 192) return 256 - 2 * (p - 63);
                else return 2 * (p - 191);
            end
            default: return p;
        endcase
    endfunction

    function automatic string shape_tag(int f);
        case (f)
            0: return "R7";
            1: return "R5";
            2: return "R6";
            default: return "R4";
        endcase
    endfunction

    // Driver: strobe one sample and queue its expected result.
    task automatic drive_sample(int f, string tag);
        item_t it;
        @(negedge clk);
        fsel = f[1:0];
        sample_en = 1'b1;
        it.a = f * 256 + model_phase;
        it.v = exp_amp(f, model_phase);
        it.tag = tag;
        q.push_back(it);
        model_phase = (model_phase + 1) % 256;
    endtask

    // Idle: strobe low, fsel disturbed, outputs must hold.
    task automatic idle(int n);
        @(negedge clk);
        sample_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            fsel = fsel + 2'd1;
            @(negedge clk);
            chk(addr == last_a[9:0], "R2", "addr held", addr, last_a);
            chk(amplitude == last_v[7:0], "R2", "amplitude held", amplitude, last_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        sample_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(addr == 10'h000, "R1", "addr after reset", addr, 0);
        chk(amplitude == 8'h80, "R1", "amplitude after reset", amplitude, 8'h80);
        rst_n = 1'b1;
        model_phase = 0;
        last_a = 0;
        last_v = 8'h80;
    endtask

    // Monitor: after each strobed edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            if (sample_en && rst_n) begin
                #2;
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected sample", addr, -1);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(addr == it.a[9:0], "R3", {it.tag, " addr"}, addr, it.a);
                    chk(amplitude == it.v[7:0], it.tag, "amplitude", amplitude, it.v);
                    if (it.a < 256) begin
                        case (it.a)
                            0:   chk(amplitude == 8'h80, "R7", "sine anchor 0", amplitude, 8'h80);
                            1:   chk(amplitude == 8'h83, "R7", "sine anchor 1", amplitude, 8'h83);
                            2:   chk(amplitude == 8'h86, "R7", "sine anchor 2", amplitude, 8'h86);
                            3:   chk(amplitude == 8'h89, "R7", "sine anchor 3", amplitude, 8'h89);
                            64:  chk(amplitude == 8'hFF, "R7", "sine peak", amplitude, 8'hFF);
                            128: chk(amplitude == 8'h7F, "R7", "sine midpoint", amplitude, 8'h7F);
                            default: ;
                        endcase
                    end
                    last_a = it.a;
                    last_v = it.v;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        sample_en = 1'b0;
        fsel = 2'd0;
        repeat (2) @(negedge clk);
        do_reset();

        // Full sweeps of every shape, back to back, crossing the phase wrap.
        for (int f = 0; f < 4; f++)
            for (int p = 0; p < 256; p++)
                drive_sample(f, shape_tag(f));
        idle(4);

        // R9: strobe set before the edge, outputs still old until that edge.
        @(negedge clk);
        fsel = 2'd3;
        sample_en = 1'b1;
        #1;
        chk(addr == last_a[9:0], "R9", "addr before edge", addr, last_a);
        chk(amplitude == last_v[7:0], "R9", "amplitude before edge", amplitude, last_v);
        begin
            item_t it;
            it.a = 3 * 256 + model_phase;
            it.v = exp_amp(3, model_phase);
            it.tag = "R9";
            q.push_back(it);
            model_phase = (model_phase + 1) % 256;
        end
        idle(2);

        // R8: shape changes on every strobe, phase keeps counting.
        for (int i = 0; i < 64; i++)
            drive_sample((i * 3 + 1) % 4, "R8");
        idle(1);

        // Gapped strobes with shape changes during the gaps.
        for (int i = 0; i < 40; i++) begin
            drive_sample(i % 4, shape_tag(i % 4));
            idle(2);
        end

        // Reset in mid sweep, then restart from phase 0.
        for (int i = 0; i < 10; i++)
            drive_sample(2, "R6");
        do_reset();
        for (int i = 0; i < 8; i++)
            drive_sample(0, "R1");
        idle(2);

        chk(q.size() == 0, "R2", "queue drained", q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule